// File: doc/BRIEF.md
# Machine-mode interrupt priority selector

This block chooses which interrupt a core running in basic (non-nested) interrupt mode should take next. It watches 32 level-sensitive interrupt lines, the per-line enable mask and the global machine interrupt enable. It also watches the data-bus response channel, so that a load or store that returns a bus error raises a non-maskable interrupt. Each cycle it presents a take-interrupt request together with the cause code of the winner. The core answers with an acknowledge when it enters the trap.

Bus-fault NMIs are captured into sticky pending flags. They are held until the core acknowledges them, and they bypass every enable. Regular lines are never captured: a line is requested only while its source holds it high and both enables allow it. Among regular lines the highest index wins, except the machine timer line, which ranks below all others. While the core is in debug mode nothing is requested. Pending NMIs survive debug mode and are offered once it ends.

Top module: `trap_irq_sel`

## Requirements
- R1: After reset release, with no line asserted and no bus fault, take_o is 0, cause_o is 0 and no NMI is pending.
- R2: A regular line i can be requested only when glb_ie_i is 1 and irq_en_mask_i[i] is 1. A line that is asserted but disabled by either enable does not raise take_o.
- R3: Among enabled asserted regular lines other than line 7, the highest index wins. cause_o then equals that index, zero-extended to 11 bits.
- R4: Line 7 (machine timer) has the lowest priority of all regular lines. cause_o is 7 only when no other enabled line is asserted.
- R5: Regular lines are level-sensitive and combinational to the outputs. take_o and cause_o follow the lines in the same cycle, and no request remains after the line drops.
- R6: A data response with dresp_valid_i=1, dresp_err_i=1 and dresp_is_store_i=0 sets the load-fault NMI pending at the next clock edge. From then on take_o is 1 with cause_o=1024, whatever glb_ie_i and irq_en_mask_i are. A response with dresp_err_i=0 raises nothing.
- R7: The same response with dresp_is_store_i=1 sets the store-fault NMI pending, which is offered with cause_o=1025.
- R8: A pending NMI outranks every regular line.
- R9: When both NMIs are pending, 1025 is offered first. Acknowledging it leaves the load NMI pending, so 1024 follows.
- R10: An NMI stays pending until ack_i is 1 in a cycle where take_o is 1 and cause_o names that NMI. It is then cleared at that clock edge.
- R11: While dbg_mode_i is 1, take_o is 0 regardless of the enables or pending NMIs. ack_i has no effect during that time, and pending NMIs are offered again after debug mode ends.
- R12: cause_o is 0 whenever take_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 32 | Level-sensitive interrupt lines |
| irq_en_mask_i | input | 32 | Per-line enable mask |
| glb_ie_i | input | 1 | Global machine interrupt enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| dresp_valid_i | input | 1 | Data-bus response valid |
| dresp_err_i | input | 1 | Data-bus response carries an error |
| dresp_is_store_i | input | 1 | Response belongs to a store (0 = load) |
| ack_i | input | 1 | Core takes the offered interrupt |
| take_o | output | 1 | Interrupt request to the core |
| cause_o | output | 11 | Cause code of the offered interrupt |

## Verification
The selector is driven with single lines and with sparse and dense multi-line patterns. Each pattern is run under several enable masks and both values of the global enable, and the result is compared with an independent priority model. This separates a highest-index rule from a lowest-index rule, and shows whether the timer demotion and the two-level enable gating are present. Bus-fault stimulus covers valid responses without an error, load faults and store faults, alone and together with active regular lines. The acknowledge sequence then separates correct NMI ordering and stickiness from premature or double clearing. A debug-mode window with pending NMIs and stray acknowledges shows that requests are suppressed without losing state.

// File: rtl/trap_irq_pkg.sv
package trap_irq_pkg;
  localparam int unsigned CAUSE_W = 11;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_NMI  = 11'd1024;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_NMI = 11'd1025;
  localparam int unsigned NMI_LOAD  = 0;
  localparam int unsigned NMI_STORE = 1;
  localparam int unsigned NMI_NUM   = 2;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LINE  = 2'd1,
    SRC_LOAD  = 2'd2,
    SRC_STORE = 2'd3
  } irq_src_e;
endpackage

// File: rtl/nmi_flag.sv
module nmi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // a new fault in the clearing cycle keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LOW_LINE  = 7,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic             hi_hit;
  logic [IDX_W-1:0] hi_idx;

  // ascending scan: last match is the highest index
  always_comb begin
    hi_hit = 1'b0;
    hi_idx = '0;
    for (int i = 0; i < int'(NUM_LINES); i++) begin
      if (i != int'(LOW_LINE) && req_i[i]) begin
        hi_hit = 1'b1;
        hi_idx = i[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    if (hi_hit) begin
      hit_o = 1'b1;
      idx_o = hi_idx;
    end else if (req_i[LOW_LINE]) begin
      hit_o = 1'b1;
      idx_o = IDX_W'(LOW_LINE);
    end else begin
      hit_o = 1'b0;
      idx_o = '0;
    end
  end
endmodule

// File: rtl/irq_cause_mux.sv
module irq_cause_mux
  import trap_irq_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic               dbg_i,
  input  logic               store_pend_i,
  input  logic               load_pend_i,
  input  logic               line_hit_i,
  input  logic [IDX_W-1:0]   line_idx_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output irq_src_e           src_o
);
  always_comb begin
    if (dbg_i)             src_o = SRC_NONE;
    else if (store_pend_i) src_o = SRC_STORE;
    else if (load_pend_i)  src_o = SRC_LOAD;
    else if (line_hit_i)   src_o = SRC_LINE;
    else                   src_o = SRC_NONE;
  end

  always_comb begin
    unique case (src_o)
      SRC_STORE: cause_o = CAUSE_STORE_NMI;
      SRC_LOAD:  cause_o = CAUSE_LOAD_NMI;
      SRC_LINE:  cause_o = {{(CAUSE_W-IDX_W){1'b0}}, line_idx_i};
      default:   cause_o = '0;
    endcase
  end

  assign take_o = (src_o != SRC_NONE);
endmodule

// File: rtl/trap_irq_sel.sv
module trap_irq_sel
  import trap_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned TIMER_LINE = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [NUM_LINES-1:0] irq_en_mask_i,
  input  logic                 glb_ie_i,
  input  logic                 dbg_mode_i,
  input  logic                 dresp_valid_i,
  input  logic                 dresp_err_i,
  input  logic                 dresp_is_store_i,
  input  logic                 ack_i,
  output logic                 take_o,
  output logic [CAUSE_W-1:0]   cause_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] line_req;
  logic                 line_hit;
  logic [IDX_W-1:0]     line_idx;
  logic                 fault;
  logic [NMI_NUM-1:0]   nmi_set;
  logic [NMI_NUM-1:0]   nmi_clr;
  logic [NMI_NUM-1:0]   nmi_pend;
  irq_src_e             src;

  assign line_req = irq_lines_i & irq_en_mask_i & {NUM_LINES{glb_ie_i}};
  assign fault    = dresp_valid_i & dresp_err_i;

  assign nmi_set[NMI_LOAD]  = fault & ~dresp_is_store_i;
  assign nmi_set[NMI_STORE] = fault &  dresp_is_store_i;
  assign nmi_clr[NMI_LOAD]  = ack_i & (src == SRC_LOAD);
  assign nmi_clr[NMI_STORE] = ack_i & (src == SRC_STORE);

  for (genvar g = 0; g < NMI_NUM; g++) begin : g_nmi
    nmi_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (nmi_set[g]),
      .clr_i  (nmi_clr[g]),
      .pend_o (nmi_pend[g])
    );
  end

  irq_prio_enc #(
    .NUM_LINES (NUM_LINES),
    .LOW_LINE  (TIMER_LINE)
  ) u_enc (
    .req_i (line_req),
    .hit_o (line_hit),
    .idx_o (line_idx)
  );

  irq_cause_mux #(
    .IDX_W (IDX_W)
  ) u_mux (
    .dbg_i        (dbg_mode_i),
    .store_pend_i (nmi_pend[NMI_STORE]),
    .load_pend_i  (nmi_pend[NMI_LOAD]),
    .line_hit_i   (line_hit),
    .line_idx_i   (line_idx),
    .take_o       (take_o),
    .cause_o      (cause_o),
    .src_o        (src)
  );
endmodule

module trap_irq_sel_chk #(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_lines_i,
  input logic [NUM_LINES-1:0] irq_en_mask_i,
  input logic                 glb_ie_i,
  input logic                 dbg_mode_i,
  input logic                 dresp_valid_i,
  input logic                 dresp_err_i,
  input logic                 dresp_is_store_i,
  input logic                 ack_i,
  input logic                 take_o,
  input logic [10:0]          cause_o,
  input logic                 load_pend_i,
  input logic                 store_pend_i
);
  AST_DBG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_i |-> !take_o); // R11

  AST_IDLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> cause_o == 11'd0); // R12

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (load_pend_i || store_pend_i ||
                (glb_ie_i && |(irq_lines_i & irq_en_mask_i)))); // R2

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dresp_valid_i && dresp_err_i && !dresp_is_store_i) |=> load_pend_i); // R6

  AST_STORE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dresp_valid_i && dresp_err_i && dresp_is_store_i) |=> store_pend_i); // R7

  AST_STORE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_pend_i && !(ack_i && take_o && cause_o == 11'd1025)) |=> store_pend_i); // R10

  AST_LOAD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_pend_i && !(ack_i && take_o && cause_o == 11'd1024)) |=> load_pend_i); // R10

  AST_STORE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && store_pend_i) |-> cause_o == 11'd1025); // R9

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !load_pend_i && !store_pend_i) |-> cause_o < 11'(NUM_LINES)); // R3
endmodule

bind trap_irq_sel trap_irq_sel_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .irq_lines_i      (irq_lines_i),
  .irq_en_mask_i    (irq_en_mask_i),
  .glb_ie_i         (glb_ie_i),
  .dbg_mode_i       (dbg_mode_i),
  .dresp_valid_i    (dresp_valid_i),
  .dresp_err_i      (dresp_err_i),
  .dresp_is_store_i (dresp_is_store_i),
  .ack_i            (ack_i),
  .take_o           (take_o),
  .cause_o          (cause_o),
  .load_pend_i      (nmi_pend[0]),
  .store_pend_i     (nmi_pend[1])
);

// File: tb/trap_irq_sel_bench.sv
module trap_irq_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [31:0] mask = '0;
  logic        ie = 1'b0;
  logic        dbg = 1'b0;
  logic        dv = 1'b0;
  logic        de = 1'b0;
  logic        ds = 1'b0;
  logic        ack = 1'b0;
  logic        take;
  logic [10:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_irq_sel u_trap_irq_sel (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .irq_en_mask_i(mask),
    .glb_ie_i(ie), .dbg_mode_i(dbg), .dresp_valid_i(dv), .dresp_err_i(de),
    .dresp_is_store_i(ds), .ack_i(ack), .take_o(take), .cause_o(cause)
  );

  function automatic logic [10:0] ref_cause(input logic [31:0] l, input logic [31:0] m,
                                            input logic e);
    logic [31:0] act;
    act = l & m & {32{e}};
    for (int i = 31; i >= 0; i--)
      if (i != 7 && act[i]) return 11'(i);
    if (act[7]) return 11'd7;
    return 11'd0;
  endfunction

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic fault(input logic is_store, input logic err);
    @(negedge clk);
    dv = 1'b1; de = err; ds = is_store;
    @(negedge clk);
    dv = 1'b0; de = 1'b0; ds = 1'b0;
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 take", 11'(take), 11'd0);
    chk("R1 cause", cause, 11'd0);
    chk("R12 idle cause", cause, 11'd0);
  endtask

  task automatic t_enables();
    lines = 32'h8000_0010; mask = 32'hFFFF_FFFF; ie = 1'b0;
    settle();
    chk("R2 global off take", 11'(take), 11'd0);
    ie = 1'b1; mask = 32'h7FFF_FFFF;
    settle();
    chk("R2 mask gates line 31", cause, 11'd4);
    mask = 32'h0; settle();
    chk("R2 all masked", 11'(take), 11'd0);
    mask = 32'hFFFF_FFFF; settle();
    chk("R3 highest wins", cause, 11'd31);
  endtask

  task automatic t_patterns();
    logic [31:0] pats [6];
    logic [31:0] msks [3];
    pats = '{32'h0000_0001, 32'h0000_0081, 32'h0001_0100, 32'hFFFF_FFFF, 32'h0000_0080, 32'h4000_0300};
    msks = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'hAAAA_AAAA};
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 3; k++) begin
        for (int e = 0; e < 2; e++) begin
          lines = pats[p]; mask = msks[k]; ie = e[0];
          settle();
          chk("R3 pattern cause", cause, ref_cause(pats[p], msks[k], e[0]));
          chk("R2 pattern take", 11'(take),
              11'(|(pats[p] & msks[k] & {32{e[0]}})));
        end
      end
    end
  endtask

  task automatic t_timer();
    ie = 1'b1; mask = 32'hFFFF_FFFF;
    lines = 32'h0000_0081; settle();
    chk("R4 timer below line 0", cause, 11'd0);
    lines = 32'h0000_0080; settle();
    chk("R4 timer alone", cause, 11'd7);
    lines = 32'h0000_0180; settle();
    chk("R4 timer below line 8", cause, 11'd8);
  endtask

  task automatic t_level();
    ie = 1'b1; mask = 32'hFFFF_FFFF;
    lines = 32'h0000_0020;
    @(negedge clk); #1;
    chk("R5 line seen", cause, 11'd5);
    lines = 32'h0; #1;
    chk("R5 drop same cycle", 11'(take), 11'd0);
    settle();
    chk("R5 no memory", 11'(take), 11'd0);
  endtask

  task automatic t_load_nmi();
    lines = 32'h8000_0000; mask = 32'h0; ie = 1'b0;
    fault(1'b0, 1'b0);
    chk("R6 valid without err", 11'(take), 11'd0);
    fault(1'b0, 1'b1);
    chk("R6 load NMI ignores enables", cause, 11'd1024);
    mask = 32'hFFFF_FFFF; ie = 1'b1; settle();
    chk("R8 NMI above line 31", cause, 11'd1024);
    settle();
    chk("R10 load still pending", cause, 11'd1024);
    pulse_ack();
    chk("R10 ack cleared load", cause, 11'd31);
    lines = 32'h0; settle();
    chk("R10 nothing left", 11'(take), 11'd0);
  endtask

  task automatic t_both_nmi();
    lines = 32'h0; mask = 32'h0; ie = 1'b0;
    fault(1'b0, 1'b1);
    fault(1'b1, 1'b1);
    chk("R7 store NMI cause", cause, 11'd1025);
    settle();
    chk("R9 store first held", cause, 11'd1025);
    pulse_ack();
    chk("R9 load follows", cause, 11'd1024);
    pulse_ack();
    chk("R10 both cleared", 11'(take), 11'd0);
  endtask

  task automatic t_debug();
    lines = 32'h0000_0004; mask = 32'hFFFF_FFFF; ie = 1'b1; dbg = 1'b1;
    settle();
    chk("R11 lines silent in debug", 11'(take), 11'd0);
    fault(1'b0, 1'b1);
    chk("R11 NMI silent in debug", 11'(take), 11'd0);
    pulse_ack();
    dbg = 1'b0; #1;
    chk("R11 NMI kept through debug", cause, 11'd1024);
    pulse_ack();
    chk("R11 line after NMI", cause, 11'd2);
    lines = 32'h0; settle();
    chk("R12 idle after debug", cause, 11'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_patterns();
    t_timer();
    t_level();
    t_load_nmi();
    t_both_nmi();
    t_debug();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule